// File: doc/BRIEF.md
# Compare-Match Event Timer

This peripheral keeps a free-running 64-bit up counter and one timer channel that raises an interrupt when the counter reaches a programmed comparator value. Software reaches it over a simple 32-bit register bus. Each 64-bit register takes two word addresses, with the low word at the lower address. The channel runs either one-shot, firing once per comparator setting, or periodic. In periodic mode the comparator moves forward by a stored period on every match.

The interrupt line signals in one of two ways. In edge mode it gives a single-cycle pulse. In level mode it holds high until software writes one to the status bit. A match always records a status bit, and a channel enable bit gates whether that status reaches the line. A global enable bit both starts the counter and gates the line. A 32-bit mode narrows the match to the low counter word.

Writes are accepted on the rising clock edge while `bus_wr` is high. Reads are combinational from `bus_addr` and have no side effects. Writes to unlisted addresses or read-only bits are ignored.

Top module: `evt_timer`

## Requirements
- R1: After reset the counter reads 0, both comparator words read 0xFFFFFFFF, the global config (0x010) reads 0, the status (0x020) reads 0, the channel config (0x100) reads 0x00000030, and `irq` is low.
- R2: The capability low word (0x000) reads 0x00002000: bit 13 = 1 marks a 64-bit counter, and bits 12:8 = 0 mean one channel. The high word (0x004) reads the tick period in femtoseconds given by parameter `PERIOD_FS`.
- R3: The counter (low word 0x0F0, high word 0x0F4) advances by one per clock while global config bit 0 is 1, carries into the high word, and holds while bit 0 is 0. A write to either word replaces that word.
- R4: Global config bit 0 is the enable and bit 1 is stored and read back. All other bits read 0. While bit 0 is 0 no match is taken, even with counter equal to comparator.
- R5: With the enable set, the cycle in which the counter equals the comparator (low 0x108, high 0x10C) sets status bit 0 one clock later. When channel config bit 8 is 1, only the low 32 bits take part in the compare.
- R6: In one-shot mode (channel config bit 3 = 0) a match leaves the comparator unchanged.
- R7: In periodic mode (bit 3 = 1) each match adds the stored period to the comparator.
- R8: When channel config bit 6 is 1 in periodic mode, a comparator low-word write also loads the low period word. A high-word write also loads the high period word and clears bit 6. When bit 6 is 0, comparator writes leave the period unchanged.
- R9: In edge mode (bit 1 = 0) with bit 2 = 1, `irq` pulses high for exactly one cycle, one clock after the match, and needs no acknowledge.
- R10: In level mode (bit 1 = 1) with bit 2 = 1, `irq` follows status bit 0. A write of 1 to bit 0 of 0x020 clears the status; a write of 0 has no effect.
- R11: With channel config bit 2 = 0, `irq` stays low while the status bit still sets on a match.
- R12: Channel config bits 4 and 5 always read 1 and ignore writes. Bits 13:9 hold a 5-bit route number that reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte address of the 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Interrupt line (pulse or level) |

## Verification
A register write takes effect at the edge that captures it, and the read data for that register is valid in the same low phase right after it. Once the global enable write has landed, the counter gains exactly one per clock. The cycle in which the counter equals the comparator is the match cycle. Status, the edge pulse, the level line and a periodic comparator advance all appear one clock after the match. The bench drives and samples on falling edges. It numbers those edges from the enabling write, so every expected match index follows from the start and compare values written by the bench: with a counter start of 0 and a comparator of 20, for example, the pulse is seen at the 21st falling edge.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int DW     = 32;
  localparam int CNT_W  = 64;
  localparam int NW     = CNT_W / DW;
  localparam int NUM_CH = 1;

  // word byte offsets; software decodes these
  localparam int unsigned OFS_CAPS = 'h000;
  localparam int unsigned OFS_GCFG = 'h010;
  localparam int unsigned OFS_STAT = 'h020;
  localparam int unsigned OFS_CNT  = 'h0F0;
  localparam int unsigned OFS_TCFG = 'h100;
  localparam int unsigned OFS_CMP  = 'h108;

  // channel config bit positions
  localparam int B_LVL    = 1;
  localparam int B_IEN    = 2;
  localparam int B_PER    = 3;
  localparam int B_PCAP   = 4;
  localparam int B_WCAP   = 5;
  localparam int B_VSET   = 6;
  localparam int B_NARROW = 8;
  localparam int B_ROUTE  = 9;
  localparam int ROUTE_W  = 5;

  typedef struct packed {
    logic [ROUTE_W-1:0] route;
    logic               narrow;
    logic               vset;
    logic               per;
    logic               ien;
    logic               lvl;
  } chan_cfg_t;

  function automatic logic cmp_match(input logic [CNT_W-1:0] cnt,
                                     input logic [CNT_W-1:0] cmp,
                                     input logic narrow);
    if (narrow) return cnt[DW-1:0] == cmp[DW-1:0];
    return cnt == cmp;
  endfunction

  function automatic logic [CNT_W-1:0] cmp_advance(input logic [CNT_W-1:0] cmp,
                                                   input logic [CNT_W-1:0] per,
                                                   input logic narrow);
    if (narrow) return {cmp[CNT_W-1:DW], cmp[DW-1:0] + per[DW-1:0]};
    return cmp + per;
  endfunction
endpackage

// File: rtl/evt_main_counter.sv
module evt_main_counter
  import evt_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic [NW-1:0]    wr_word,
  input  logic [DW-1:0]    wdata,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_inc, cnt_d;

  assign cnt_inc = count_en ? cnt_q + 1'b1 : cnt_q;

  for (genvar w = 0; w < NW; w++) begin : g_lane
    assign cnt_d[w*DW +: DW] = wr_word[w] ? wdata : cnt_inc[w*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && wr_word == '0) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && wr_word == '0) |=> $stable(cnt_q));
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cfg_wr,
  input  logic [NW-1:0]    cmp_wr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    cfg_rd,
  output logic [CNT_W-1:0] cmp,
  output logic             hit,
  output logic             lvl,
  output logic             ien
);
  chan_cfg_t        cfg_q;
  logic [CNT_W-1:0] cmp_q, per_q, cmp_adv, cmp_d, per_d;

  assign hit     = gen_en && cmp_match(cnt, cmp_q, cfg_q.narrow);
  assign cmp_adv = (hit && cfg_q.per) ? cmp_advance(cmp_q, per_q, cfg_q.narrow) : cmp_q;

  for (genvar w = 0; w < NW; w++) begin : g_lane
    assign cmp_d[w*DW +: DW] = cmp_wr[w] ? wdata : cmp_adv[w*DW +: DW];
    assign per_d[w*DW +: DW] = (cmp_wr[w] && cfg_q.vset && cfg_q.per) ? wdata
                                                                      : per_q[w*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cmp_q <= '1;
      per_q <= '0;
    end else begin
      cmp_q <= cmp_d;
      per_q <= per_d;
      if (cfg_wr) begin
        cfg_q.lvl    <= wdata[B_LVL];
        cfg_q.ien    <= wdata[B_IEN];
        cfg_q.per    <= wdata[B_PER];
        cfg_q.vset   <= wdata[B_VSET];
        cfg_q.narrow <= wdata[B_NARROW];
        cfg_q.route  <= wdata[B_ROUTE +: ROUTE_W];
      end else if (cmp_wr[NW-1]) begin
        cfg_q.vset <= 1'b0;
      end
    end
  end

  always_comb begin
    cfg_rd                      = '0;
    cfg_rd[B_LVL]               = cfg_q.lvl;
    cfg_rd[B_IEN]               = cfg_q.ien;
    cfg_rd[B_PER]               = cfg_q.per;
    cfg_rd[B_PCAP]              = 1'b1;
    cfg_rd[B_WCAP]              = (CNT_W == 64);
    cfg_rd[B_VSET]              = cfg_q.vset;
    cfg_rd[B_NARROW]            = cfg_q.narrow;
    cfg_rd[B_ROUTE +: ROUTE_W]  = cfg_q.route;
  end

  assign cmp = cmp_q;
  assign lvl = cfg_q.lvl;
  assign ien = cfg_q.ien;

  a_r6_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cfg_q.per && cmp_wr == '0) |=> $stable(cmp_q));
  a_r7_periodic_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cfg_q.per && !cfg_q.narrow && cmp_wr == '0)
      |=> cmp_q == $past(cmp_q) + $past(per_q));
  a_r8_vset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr[NW-1] |=> !cfg_q.vset);
  a_r8_period_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.vset) |=> $stable(per_q));
endmodule

// File: rtl/evt_irq_gen.sv
module evt_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic gen_en,
  input  logic hit,
  input  logic lvl,
  input  logic ien,
  input  logic ack,
  output logic status,
  output logic irq
);
  logic status_q, pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      if (hit)      status_q <= 1'b1;
      else if (ack) status_q <= 1'b0;
      pulse_q <= hit && ien && !lvl;
    end
  end

  assign status = status_q;
  assign irq    = gen_en && (lvl ? (ien && status_q) : pulse_q);

  a_r5_status_set: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> status_q);
  a_r10_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !ack) |=> status_q);
  a_r9_pulse_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl && irq) |-> $past(hit));
  a_r11_ien_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien && lvl) |-> !irq);
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter logic [31:0] PERIOD_FS = 32'd69841279,
  parameter int          ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam logic [DW-1:0] CAPS_LO = DW'(((CNT_W == 64) ? 1 : 0) << 13)
                                    | DW'((NUM_CH - 1) << 8);

  logic             gen_en_q, aux_q;
  logic [NW-1:0]    cnt_wr, cmp_wr;
  logic             gcfg_wr, stat_wr, tcfg_wr;
  logic [CNT_W-1:0] cnt, cmp;
  logic [DW-1:0]    cfg_rd;
  logic             hit, lvl, ien, status;

  assign gcfg_wr = bus_wr && (bus_addr == ADDR_W'(OFS_GCFG));
  assign stat_wr = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
  assign tcfg_wr = bus_wr && (bus_addr == ADDR_W'(OFS_TCFG));

  for (genvar w = 0; w < NW; w++) begin : g_wsel
    assign cnt_wr[w] = bus_wr && (bus_addr == ADDR_W'(OFS_CNT + 4*w));
    assign cmp_wr[w] = bus_wr && (bus_addr == ADDR_W'(OFS_CMP + 4*w));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_en_q <= 1'b0;
      aux_q    <= 1'b0;
    end else if (gcfg_wr) begin
      gen_en_q <= bus_wdata[0];
      aux_q    <= bus_wdata[1];
    end
  end

  evt_main_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .count_en(gen_en_q),
    .wr_word(cnt_wr), .wdata(bus_wdata), .cnt(cnt)
  );

  evt_channel u_ch (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en_q), .cnt(cnt),
    .cfg_wr(tcfg_wr), .cmp_wr(cmp_wr), .wdata(bus_wdata),
    .cfg_rd(cfg_rd), .cmp(cmp), .hit(hit), .lvl(lvl), .ien(ien)
  );

  evt_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en_q), .hit(hit),
    .lvl(lvl), .ien(ien), .ack(stat_wr && bus_wdata[0]),
    .status(status), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_CAPS):     bus_rdata = CAPS_LO;
      ADDR_W'(OFS_CAPS + 4): bus_rdata = PERIOD_FS;
      ADDR_W'(OFS_GCFG):     bus_rdata = {30'b0, aux_q, gen_en_q};
      ADDR_W'(OFS_STAT):     bus_rdata = {31'b0, status};
      ADDR_W'(OFS_TCFG):     bus_rdata = cfg_rd;
      default:               bus_rdata = '0;
    endcase
    for (int w = 0; w < NW; w++) begin
      if (bus_addr == ADDR_W'(OFS_CNT + 4*w)) bus_rdata = cnt[w*DW +: DW];
      if (bus_addr == ADDR_W'(OFS_CMP + 4*w)) bus_rdata = cmp[w*DW +: DW];
    end
  end

  a_r4_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en_q |-> !irq);
  a_r4_no_hit_off: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en_q |=> !$rose(status));
endmodule

// File: tb/evt_timer_bench.sv
module evt_timer_bench;
  localparam int          CLK_P  = 10;
  localparam logic [31:0] PER_FS = 32'd69841279;
  localparam int          WDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  evt_timer #(.PERIOD_FS(PER_FS), .ADDR_W(12)) u_evt_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rchk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  // disable, clear status, program channel, comparator and counter
  task automatic setup(input logic [31:0] cfg, input logic [31:0] cmp_lo,
                       input logic [31:0] cmp_hi, input logic [31:0] cnt_lo,
                       input logic [31:0] cnt_hi);
    wr(12'h010, 0);
    wr(12'h020, 1);
    wr(12'h100, cfg);
    wr(12'h108, cmp_lo);
    wr(12'h10C, cmp_hi);
    wr(12'h0F0, cnt_lo);
    wr(12'h0F4, cnt_hi);
  endtask

  task automatic t_reset();
    chk("R1 irq after reset", {31'b0, irq}, 0);
    rchk("R1 counter lo", 12'h0F0, 0);
    rchk("R1 counter hi", 12'h0F4, 0);
    rchk("R1 comparator lo", 12'h108, 32'hFFFF_FFFF);
    rchk("R1 comparator hi", 12'h10C, 32'hFFFF_FFFF);
    rchk("R1 global config", 12'h010, 0);
    rchk("R1 status", 12'h020, 0);
    rchk("R1 channel config", 12'h100, 32'h30);
    rchk("R2 caps lo", 12'h000, 32'h0000_2000);
    rchk("R2 caps hi period", 12'h004, PER_FS);
  endtask

  task automatic t_count();
    setup(0, 0, 0, 100, 0);
    rchk("R3 counter write lo", 12'h0F0, 100);
    wr(12'h010, 1);
    repeat (5) @(negedge clk);
    rchk("R3 counts 5 clocks", 12'h0F0, 105);
    wr(12'h010, 0);
    // the disabling write's edge still counted once
    rchk("R3 stops on disable", 12'h0F0, 107);
    repeat (3) @(negedge clk);
    rchk("R3 holds while disabled", 12'h0F0, 107);
    wr(12'h0F4, 7);
    rchk("R3 counter write hi", 12'h0F4, 7);
    wr(12'h0F0, 32'hFFFF_FFFE);
    wr(12'h0F4, 0);
    wr(12'h010, 1);
    repeat (3) @(negedge clk);
    rchk("R3 carry lo", 12'h0F0, 1);
    rchk("R3 carry hi", 12'h0F4, 1);
    wr(12'h010, 0);
  endtask

  task automatic t_gcfg();
    wr(12'h010, 32'hFFFF_FFFE);
    rchk("R4 aux bit kept, others zero", 12'h010, 32'h2);
    setup(32'h6, 5, 0, 5, 0);
    repeat (4) @(negedge clk);
    rchk("R4 no match while disabled", 12'h020, 0);
    chk("R4 irq low while disabled", {31'b0, irq}, 0);
  endtask

  task automatic t_oneshot_edge();
    int first = 0;
    int hits = 0;
    setup(32'h4, 20, 0, 0, 0);
    wr(12'h010, 1);
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (irq) begin hits++; if (first == 0) first = i; end
    end
    chk("R9 edge pulse index", first, 21);
    chk("R9 single one-cycle pulse", hits, 1);
    rchk("R6 one-shot comparator unchanged", 12'h108, 20);
    rchk("R5 status set on match", 12'h020, 1);
  endtask

  task automatic t_periodic();
    int first = 0;
    int hits = 0;
    setup(32'h4C, 10, 0, 0, 0);
    rchk("R8 value-set cleared by high write", 12'h100, 32'h3C);
    wr(12'h010, 1);
    for (int i = 1; i <= 35; i++) begin
      @(negedge clk);
      if (irq) begin hits++; if (first == 0) first = i; end
    end
    chk("R7 first periodic pulse", first, 11);
    chk("R7 three periodic pulses", hits, 3);
    rchk("R7 comparator advanced", 12'h108, 40);
    setup(32'h0C, 5, 0, 0, 0);
    wr(12'h010, 1);
    repeat (8) @(negedge clk);
    rchk("R8 period kept without value-set", 12'h108, 15);
  endtask

  task automatic t_level();
    logic [31:0] st;
    setup(32'h6, 6, 0, 0, 0);
    wr(12'h010, 1);
    repeat (6) @(negedge clk);
    chk("R10 irq low before match", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R10 irq high after match", {31'b0, irq}, 1);
    repeat (8) @(negedge clk);
    chk("R10 level held", {31'b0, irq}, 1);
    wr(12'h020, 0);
    chk("R10 write 0 no effect", {31'b0, irq}, 1);
    wr(12'h020, 1);
    chk("R10 write 1 clears irq", {31'b0, irq}, 0);
    rd(12'h020, st);
    chk("R10 status cleared", st, 0);
  endtask

  task automatic t_ien_off();
    int seen = 0;
    setup(32'h2, 3, 0, 0, 0);
    wr(12'h010, 1);
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (irq) seen++;
    end
    chk("R11 irq stays low", seen, 0);
    rchk("R11 status still set", 12'h020, 1);
  endtask

  task automatic t_narrow();
    setup(32'h106, 4, 0, 0, 1);
    wr(12'h010, 1);
    repeat (6) @(negedge clk);
    rchk("R5 32-bit mode matches low word", 12'h020, 1);
    setup(32'h006, 4, 0, 0, 1);
    wr(12'h010, 1);
    repeat (6) @(negedge clk);
    rchk("R5 64-bit mode needs high word", 12'h020, 0);
  endtask

  task automatic t_cfgbits();
    wr(12'h010, 0);
    wr(12'h100, 32'h0000_3E30);
    rchk("R12 route all ones", 12'h100, 32'h3E30);
    wr(12'h100, 0);
    rchk("R12 caps bits read 1", 12'h100, 32'h30);
    wr(12'h100, 32'h1000);
    rchk("R12 route value 8", 12'h100, 32'h1030);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_gcfg();
    t_oneshot_edge();
    t_periodic();
    t_level();
    t_ien_off();
    t_narrow();
    t_cfgbits();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule